// File: doc/BRIEF.md
# Macro ALU and Bitfield Datapath

This block is the arithmetic core of a small command-macro engine. Each cycle in which `op_valid` is high it takes two register operands, a signed immediate, three bit-position fields and an operation selector. It then forms one result word. The result is one of four things: a register-to-register ALU result, an immediate sum, a bitfield insertion, or a bitfield extraction followed by a left shift. The shift distances come from either an immediate field or a register value.

The block keeps one carry flag. Only the four arithmetic ALU functions change it, so multi-word additions and subtractions can be chained across instructions. For the read operation, the block drives the word address of an external register space as the low bits of operand A plus the immediate. The word that comes back on `rd_data` in the same cycle becomes the result. The result, its valid strobe and the carry flag are registered and appear one clock after the operation is presented. The instruction sequencer and the register file sit outside this block.

Top module: `macro_alu_dp`

## Requirements
- R1: With `op_kind`=0 (ALU), `alu_fn` codes 4,5,6,7,8 return A XOR B, A OR B, A AND B, A AND NOT B and NOT(A AND B). The carry flag is left as it was.
- R2: ALU code 0 (add) returns A+B, and ALU code 1 (add with carry) returns A+B+carry. Both load the carry flag with bit W of the W+1-bit sum.
- R3: ALU code 2 (subtract) returns A−B, and ALU code 3 returns A−B−(1−carry). Both set the carry flag to 1 exactly when no borrow occurred, which means the carry holds a "no borrow" meaning.
- R4: `op_kind`=1 returns A plus the immediate sign-extended from bit IMM_W−1, wrapping at W bits. The carry flag is never changed by this kind, or by kinds 2 to 5.
- R5: `op_kind`=2 takes `fld_size` bits of B from bit `fld_src` upward and writes them into A from bit `fld_dst` upward. All other bits of A are kept, and bits shifted past bit W−1 are dropped.
- R6: `op_kind`=3 shifts B right by the full value of A, keeps the low `fld_size` bits, then shifts that left by `fld_dst`. A shift amount of W or more gives zero.
- R7: `op_kind`=4 shifts B right by `fld_src`, keeps the low `fld_size` bits, then shifts that left by the full value of A. A left shift of W or more gives zero, and bits past bit W−1 are dropped.
- R8: A field size of zero is an empty field. Kind 2 then returns A unchanged, and kinds 3 and 4 return zero.
- R9: `rd_addr` always shows the low ADDR_W bits of A plus the sign-extended immediate, without a register stage. With `op_kind`=5, the result is `rd_data` as sampled in the cycle of the operation.
- R10: The result and carry of an operation appear one clock after the cycle in which `op_valid` is high, and `result_vld` is high for that one cycle. When `op_valid` is low, the result and the carry hold their values.
- R11: While `rst_n` is low, the result, `result_vld` and the carry flag are all zero.
- R12: An `op_kind` of 6 or 7 changes neither the result nor the carry and does not raise `result_vld`. An ALU code of 9 to 15 returns zero and leaves the carry unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_kind | input | 3 | Operation kind (0 ALU, 1 immediate add, 2 insert, 3 extract with immediate left shift, 4 extract with register left shift, 5 read) |
| alu_fn | input | 4 | ALU function code used when op_kind is 0 |
| opa | input | W | Operand A |
| opb | input | W | Operand B |
| imm | input | IMM_W | Signed immediate |
| fld_src | input | POS_W | Source bit position of a field |
| fld_size | input | POS_W | Field width in bits |
| fld_dst | input | POS_W | Destination bit position of a field |
| rd_data | input | W | Word returned from the external register space |
| rd_addr | output | ADDR_W | Word address for the external register space |
| result | output | W | Registered result |
| result_vld | output | 1 | Result updated by the previous cycle's operation |
| carry | output | 1 | Carry / no-borrow flag |

## Verification
The bench uses the default parameters: a 32-bit word, an 18-bit immediate, 5-bit position fields and a 12-bit address. With a 32-bit word, carry and borrow out of bit 31 can be reached from simple operands. With an 18-bit immediate, negative values such as 0x3FFFF and 0x20000 test the sign extension. Because the position fields are 5 bits wide, register-sourced shift amounts of 32 and above, and fields that run past bit 31, are both checked. The carry chain is tested with a sequence of operations in which each step depends on the flag left by the step before.

// File: rtl/mdp_pkg.sv
package mdp_pkg;

    localparam int KIND_W = 3;
    localparam int FN_W   = 4;

    typedef enum logic [KIND_W-1:0] {
        K_ALU   = 3'd0,
        K_ADDI  = 3'd1,
        K_BFREP = 3'd2,
        K_BFXI  = 3'd3,
        K_BFXR  = 3'd4,
        K_READ  = 3'd5
    } kind_e;

    typedef enum logic [FN_W-1:0] {
        F_ADD  = 4'd0,
        F_ADC  = 4'd1,
        F_SUB  = 4'd2,
        F_SBB  = 4'd3,
        F_XOR  = 4'd4,
        F_OR   = 4'd5,
        F_AND  = 4'd6,
        F_ANDN = 4'd7,
        F_NAND = 4'd8
    } alu_fn_e;

endpackage

// File: rtl/mdp_alu.sv
module mdp_alu
    import mdp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            chk_en,
    input  logic [FN_W-1:0] fn,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic            cin,
    output logic [W-1:0]    res,
    output logic            cout,
    output logic            arith
);

    logic [W-1:0] b_eff;
    logic         ci;
    logic [W:0]   sum;

    // Operand conditioning: subtraction is A + ~B + carry-in
    always_comb begin
        arith = 1'b1;
        b_eff = b;
        ci    = 1'b0;
        case (fn)
            F_ADD: ci = 1'b0;
            F_ADC: ci = cin;
            F_SUB: begin
                b_eff = ~b;
                ci    = 1'b1;
            end
            F_SBB: begin
                b_eff = ~b;
                ci    = cin;
            end
            default: arith = 1'b0;
        endcase
    end

    assign sum  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, ci};
    assign cout = sum[W];

    always_comb begin
        case (fn)
            F_ADD, F_ADC, F_SUB, F_SBB: res = sum[W-1:0];
            F_XOR:  res = a ^ b;
            F_OR:   res = a | b;
            F_AND:  res = a & b;
            F_ANDN: res = a & ~b;
            F_NAND: res = ~(a & b);
            default: res = '0;
        endcase
    end

    AST_ADD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && fn == F_ADD) |-> (cout == (res < a)));  // R2
    AST_SUB_NOBORROW: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && fn == F_SUB) |-> (cout == (a >= b)));  // R3
    AST_NAND_DUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && fn == F_NAND) |-> ((res ^ (a & b)) == {W{1'b1}}));  // R1
    AST_BAD_FN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && fn > F_NAND) |-> (res == '0 && !arith));  // R12

endmodule

// File: rtl/mdp_bitfield.sv
module mdp_bitfield #(
    parameter int W     = 32,
    parameter int POS_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chk_en,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  logic [POS_W-1:0] src,
    input  logic [POS_W-1:0] size,
    input  logic [POS_W-1:0] dst,
    output logic [W-1:0]     rep,
    output logic [W-1:0]     xi,
    output logic [W-1:0]     xr
);

    logic [W-1:0] mask;
    logic [W-1:0] hole;
    logic [W-1:0] fld_at_src;
    logic [W-1:0] fld_at_a;

    // Size zero makes an empty mask
    assign mask       = ~({W{1'b1}} << size);
    assign hole       = mask << dst;
    assign fld_at_src = (b >> src) & mask;
    assign fld_at_a   = (b >> a) & mask;

    assign rep = (a & ~hole) | (fld_at_src << dst);
    assign xi  = fld_at_a << dst;
    assign xr  = fld_at_src << a;

    AST_REP_KEEPS_REST: assert property (@(posedge clk) disable iff (!rst_n)
        chk_en |-> (((rep ^ a) & ~hole) == '0));  // R5
    AST_XI_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        chk_en |-> ((xi & ~hole) == '0));  // R6
    AST_XR_FAR_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && a >= W) |-> (xr == '0));  // R7
    AST_EMPTY_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && size == '0) |-> (rep == a && xi == '0 && xr == '0));  // R8

endmodule

// File: rtl/mdp_addgen.sv
module mdp_addgen #(
    parameter int W      = 32,
    parameter int IMM_W  = 18,
    parameter int ADDR_W = 12
) (
    input  logic [W-1:0]      a,
    input  logic [IMM_W-1:0]  imm,
    output logic [W-1:0]      sum,
    output logic [ADDR_W-1:0] addr
);

    localparam int EXT_W = W - IMM_W;

    logic [W-1:0] imm_ext;

    assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
    assign sum     = a + imm_ext;

    generate
        if (ADDR_W <= W) begin : g_trunc
            assign addr = sum[ADDR_W-1:0];
        end else begin : g_widen
            assign addr = {{(ADDR_W-W){1'b0}}, sum};
        end
    endgenerate

endmodule

// File: rtl/macro_alu_dp.sv
module macro_alu_dp
    import mdp_pkg::*;
#(
    parameter int W      = 32,
    parameter int IMM_W  = 18,
    parameter int POS_W  = 5,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_kind,
    input  logic [3:0]        alu_fn,
    input  logic [W-1:0]      opa,
    input  logic [W-1:0]      opb,
    input  logic [IMM_W-1:0]  imm,
    input  logic [POS_W-1:0]  fld_src,
    input  logic [POS_W-1:0]  fld_size,
    input  logic [POS_W-1:0]  fld_dst,
    input  logic [W-1:0]      rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [W-1:0]      result,
    output logic              result_vld,
    output logic              carry
);

    typedef struct packed {
        logic [W-1:0] res;
        logic         vld;
        logic         cy;
    } st_t;

    st_t st_d, st_q;

    logic         alu_en, bf_en;
    logic [W-1:0] alu_res, imm_sum, rep_res, xi_res, xr_res;
    logic         alu_cout, alu_arith;

    assign alu_en = op_valid && (op_kind == K_ALU);
    assign bf_en  = op_valid && (op_kind == K_BFREP || op_kind == K_BFXI || op_kind == K_BFXR);

    mdp_alu #(.W(W)) u_alu (
        .clk    (clk),
        .rst_n  (rst_n),
        .chk_en (alu_en),
        .fn     (alu_fn),
        .a      (opa),
        .b      (opb),
        .cin    (st_q.cy),
        .res    (alu_res),
        .cout   (alu_cout),
        .arith  (alu_arith)
    );

    mdp_bitfield #(.W(W), .POS_W(POS_W)) u_bf (
        .clk    (clk),
        .rst_n  (rst_n),
        .chk_en (bf_en),
        .a      (opa),
        .b      (opb),
        .src    (fld_src),
        .size   (fld_size),
        .dst    (fld_dst),
        .rep    (rep_res),
        .xi     (xi_res),
        .xr     (xr_res)
    );

    mdp_addgen #(.W(W), .IMM_W(IMM_W), .ADDR_W(ADDR_W)) u_ag (
        .a    (opa),
        .imm  (imm),
        .sum  (imm_sum),
        .addr (rd_addr)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (op_valid) begin
            case (op_kind)
                K_ALU: begin
                    st_d.res = alu_res;
                    st_d.vld = 1'b1;
                    if (alu_arith) st_d.cy = alu_cout;
                end
                K_ADDI: begin
                    st_d.res = imm_sum;
                    st_d.vld = 1'b1;
                end
                K_BFREP: begin
                    st_d.res = rep_res;
                    st_d.vld = 1'b1;
                end
                K_BFXI: begin
                    st_d.res = xi_res;
                    st_d.vld = 1'b1;
                end
                K_BFXR: begin
                    st_d.res = xr_res;
                    st_d.vld = 1'b1;
                end
                K_READ: begin
                    st_d.res = rd_data;
                    st_d.vld = 1'b1;
                end
                default: st_d.vld = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result     = st_q.res;
    assign result_vld = st_q.vld;
    assign carry      = st_q.cy;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(result) && $stable(carry) && !result_vld));  // R10
    AST_CARRY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind != K_ALU) |=> $stable(carry));  // R4
    AST_READ_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == K_READ) |=> (result == $past(rd_data)));  // R9
    AST_BAD_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind > K_READ) |=> (!result_vld && $stable(result)));  // R12
    AST_VLD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind <= K_READ) |=> result_vld);  // R10

endmodule

// File: tb/macro_alu_dp_test.sv
module macro_alu_dp_test;

    localparam int W = 32, IMM_W = 18, POS_W = 5, ADDR_W = 12;
    localparam int NV = 32;

    typedef struct packed {
        logic [2:0]  kind;
        logic [3:0]  fn;
        logic [31:0] a;
        logic [31:0] b;
        logic [17:0] imm;
        logic [4:0]  src;
        logic [4:0]  size;
        logic [4:0]  dst;
        logic [31:0] rdat;
        logic [31:0] eres;
        logic        ecy;
    } vec_t;

    // kind, fn, a, b, imm, src, size, dst, rd_data, expected result, expected carry
    localparam vec_t VEC [NV] = '{
        '{3'd0, 4'd0, 32'hFFFFFFFF, 32'h1,        18'h0, 5'd0, 5'd0, 5'd0, 32'h0, 32'h0,        1'b1}, // R2
        '{3'd0, 4'd1, 32'h1,        32'h2,        18'h0, 5'd0, 5'd0, 5'd0, 32'h0, 32'h4,        1'b0}, // R2
        '{3'd0, 4'd0, 32'h80000000, 32'h80000000, 18'h0, 5'd0, 5'd0, 5'd0, 32'h0, 32'h0,        1'b1}, // R2
        '{3'd0, 4'd1, 32'hFFFFFFFF, 32'h0,        18'h0, 5'd0, 5'd0, 5'd0, 32'h0, 32'h0,        1'b1}, // R2
        '{3'd0, 4'd4, 32'hF0F0F0F0, 32'hFF00FF00, 18'h0, 5'd0, 5'd0, 5'd0, 32'h0, 32'h0FF00FF0, 1'b1}, // R1
        '{3'd0, 4'd5, 32'h12340000, 32'h00005678, 18'h0, 5'd0, 5'd0, 5'd0, 32'h0, 32'h12345678, 1'b1}, // R1
        '{3'd0, 4'd6, 32'hFF00FF00, 32'h0F0F0F0F, 18'h0, 5'd0, 5'd0, 5'd0, 32'h0, 32'h0F000F00, 1'b1}, // R1
        '{3'd0, 4'd7, 32'hFFFF0000, 32'hF0F0F0F0, 18'h0, 5'd0, 5'd0, 5'd0, 32'h0, 32'h0F0F0000, 1'b1}, // R1
        '{3'd0, 4'd8, 32'hFFFFFFFF, 32'h0000FFFF, 18'h0, 5'd0, 5'd0, 5'd0, 32'h0, 32'hFFFF0000, 1'b1}, // R1
        '{3'd0, 4'd2, 32'h5,        32'h3,        18'h0, 5'd0, 5'd0, 5'd0, 32'h0, 32'h2,        1'b1}, // R3
        '{3'd0, 4'd2, 32'h3,        32'h5,        18'h0, 5'd0, 5'd0, 5'd0, 32'h0, 32'hFFFFFFFE, 1'b0}, // R3
        '{3'd0, 4'd3, 32'hA,        32'h3,        18'h0, 5'd0, 5'd0, 5'd0, 32'h0, 32'h6,        1'b1}, // R3
        '{3'd0, 4'd3, 32'h5,        32'h5,        18'h0, 5'd0, 5'd0, 5'd0, 32'h0, 32'h0,        1'b1}, // R3
        '{3'd0, 4'd2, 32'h0,        32'h1,        18'h0, 5'd0, 5'd0, 5'd0, 32'h0, 32'hFFFFFFFF, 1'b0}, // R3
        '{3'd0, 4'd3, 32'h0,        32'h0,        18'h0, 5'd0, 5'd0, 5'd0, 32'h0, 32'hFFFFFFFF, 1'b0}, // R3
        '{3'd1, 4'd0, 32'h100,      32'h0,    18'h3FFFF, 5'd0, 5'd0, 5'd0, 32'h0, 32'hFF,       1'b0}, // R4
        '{3'd1, 4'd0, 32'hFFFFFFFF, 32'h0,        18'h2, 5'd0, 5'd0, 5'd0, 32'h0, 32'h1,        1'b0}, // R4
        '{3'd0, 4'd0, 32'hFFFFFFFF, 32'h1,        18'h0, 5'd0, 5'd0, 5'd0, 32'h0, 32'h0,        1'b1}, // R2
        '{3'd1, 4'd0, 32'h0,        32'h0,    18'h20000, 5'd0, 5'd0, 5'd0, 32'h0, 32'hFFFE0000, 1'b1}, // R4
        '{3'd2, 4'd0, 32'hFFFFFFFF, 32'h5,        18'h0, 5'd0, 5'd3, 5'd4, 32'h0, 32'hFFFFFFDF, 1'b1}, // R5
        '{3'd2, 4'd0, 32'h0,        32'hABCD0000, 18'h0, 5'd16, 5'd16, 5'd0, 32'h0, 32'h0000ABCD, 1'b1}, // R5
        '{3'd2, 4'd0, 32'h12345678, 32'hFFFFFFFF, 18'h0, 5'd0, 5'd0, 5'd0, 32'h0, 32'h12345678, 1'b1}, // R8
        '{3'd2, 4'd0, 32'h0,        32'hFF,       18'h0, 5'd0, 5'd8, 5'd28, 32'h0, 32'hF0000000, 1'b1}, // R5
        '{3'd3, 4'd0, 32'h8,        32'h0000AB00, 18'h0, 5'd0, 5'd8, 5'd4, 32'h0, 32'h00000AB0, 1'b1}, // R6
        '{3'd3, 4'd0, 32'd40,       32'hFFFFFFFF, 18'h0, 5'd0, 5'd4, 5'd0, 32'h0, 32'h0,        1'b1}, // R6
        '{3'd3, 4'd0, 32'h0,        32'hFFFFFFFF, 18'h0, 5'd0, 5'd0, 5'd3, 32'h0, 32'h0,        1'b1}, // R8
        '{3'd4, 4'd0, 32'h8,        32'h00F00000, 18'h0, 5'd20, 5'd4, 5'd0, 32'h0, 32'h00000F00, 1'b1}, // R7
        '{3'd4, 4'd0, 32'd32,       32'hFFFFFFFF, 18'h0, 5'd0, 5'd4, 5'd0, 32'h0, 32'h0,        1'b1}, // R7
        '{3'd4, 4'd0, 32'd30,       32'hFFFFFFFF, 18'h0, 5'd0, 5'd4, 5'd0, 32'h0, 32'hC0000000, 1'b1}, // R7
        '{3'd5, 4'd0, 32'h100,      32'h0,       18'h10, 5'd0, 5'd0, 5'd0, 32'hDEADBEEF, 32'hDEADBEEF, 1'b1}, // R9
        '{3'd5, 4'd0, 32'h5,        32'h0,    18'h3FFFF, 5'd0, 5'd0, 5'd0, 32'h1234, 32'h1234,  1'b1}, // R9
        '{3'd0, 4'd9, 32'h1,        32'h1,        18'h0, 5'd0, 5'd0, 5'd0, 32'h0, 32'h0,        1'b1}  // R12
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              op_valid = 1'b0;
    logic [2:0]        op_kind = '0;
    logic [3:0]        alu_fn = '0;
    logic [W-1:0]      opa = '0, opb = '0, rd_data = '0;
    logic [IMM_W-1:0]  imm = '0;
    logic [POS_W-1:0]  fld_src = '0, fld_size = '0, fld_dst = '0;
    logic [ADDR_W-1:0] rd_addr;
    logic [W-1:0]      result;
    logic              result_vld, carry;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    macro_alu_dp #(.W(W), .IMM_W(IMM_W), .POS_W(POS_W), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .alu_fn(alu_fn), .opa(opa), .opb(opb), .imm(imm),
        .fld_src(fld_src), .fld_size(fld_size), .fld_dst(fld_dst),
        .rd_data(rd_data), .rd_addr(rd_addr), .result(result),
        .result_vld(result_vld), .carry(carry)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] exp_addr(input logic [31:0] a, input logic [17:0] im);
        logic [31:0] s;
        s = a + {{14{im[17]}}, im};
        return s[ADDR_W-1:0];
    endfunction

    task automatic apply(input vec_t v);
        @(negedge clk);
        op_valid = 1'b1; op_kind = v.kind; alu_fn = v.fn; opa = v.a; opb = v.b;
        imm = v.imm; fld_src = v.src; fld_size = v.size; fld_dst = v.dst; rd_data = v.rdat;
        #1;
        if (v.kind == 3'd5) chk("R9 rd_addr", 32'(rd_addr), 32'(exp_addr(v.a, v.imm)));
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog expired actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 reset result", result, 32'h0);
        chk("R11 reset valid", 32'(result_vld), 32'h0);
        chk("R11 reset carry", 32'(carry), 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            chk($sformatf("vector %0d result (kind %0d)", i, VEC[i].kind), result, VEC[i].eres);
            chk($sformatf("vector %0d carry", i), 32'(carry), 32'(VEC[i].ecy));
            chk($sformatf("R10 vector %0d valid", i), 32'(result_vld), 32'h1);
        end

        // R10: idle cycles with changed inputs leave result and carry alone
        apply(VEC[21]);
        opa = 32'hCAFEF00D; opb = 32'h1; op_kind = 3'd0; alu_fn = 4'd0;
        repeat (2) @(negedge clk);
        chk("R10 hold result", result, 32'h12345678);
        chk("R10 hold carry", 32'(carry), 32'h1);
        chk("R10 idle valid", 32'(result_vld), 32'h0);

        // R12: unsupported kind
        @(negedge clk);
        op_valid = 1'b1; op_kind = 3'd6; opa = 32'h0; opb = 32'h0;
        @(negedge clk);
        op_valid = 1'b0;
        chk("R12 bad kind result", result, 32'h12345678);
        chk("R12 bad kind carry", 32'(carry), 32'h1);
        chk("R12 bad kind valid", 32'(result_vld), 32'h0);

        // R11: reset in mid-run clears state
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11 rerun reset result", result, 32'h0);
        chk("R11 rerun reset carry", 32'(carry), 32'h0);
        rst_n = 1'b1;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule